// File: doc/BRIEF.md
# CRC-Checked Register Access Bridge

This block sits between a byte-level serial target front end and an 8-bit register file. The front end hands it each received byte as a valid/data pulse and marks the start and stop of each frame. The block decodes the frame, computes an 8-bit CRC over the frame's bytes, and drives a one-cycle write strobe into the register file only when the frame is complete, the CRC matches and the register address is in range. When the front end asks for bytes to send in a read frame, the block answers with the addressed register's data, followed by a CRC byte computed over that read.

A static mode input selects the protected format or the plain format. In protected mode a write frame carries a data byte and then a CRC byte, and a read returns a data byte and then a CRC byte. In plain mode both carry only the data byte. A frame that fails the CRC, or stops before its CRC byte arrives, leaves the register file untouched and raises a sticky error flag. That flag stays set until a dedicated clear input is pulsed.

Top module: `crcreg_guard`

## Requirements
- R1: After reset the write strobe, the error flag and the transmit valid are low, and the read pointer output is 0x00.
- R2: The CRC uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), seed 0xFF, most significant bit first, with no final inversion. It covers, in this order, the address byte (7-bit target address shifted left by one, bit 0 = 0 for write and 1 for read), the register address byte, then the data byte.
- R3: In protected mode, a write frame (address byte bit 0 = 0, register byte, data byte, CRC byte) with a matching CRC raises rf_we for exactly one cycle. The pulse comes in the cycle after the CRC byte is accepted and carries that register address and data.
- R4: In protected mode, a CRC byte that does not match produces no write and sets crc_error in the cycle after that byte.
- R5: In protected mode, a stop or a new start that arrives after the data byte but before the CRC byte produces no write and sets crc_error.
- R6: In plain mode, the write is committed in the cycle after the data byte, and crc_error is never set.
- R7: A register address of 0x83 or above is never written in either mode, and does not set crc_error when its CRC matches. A read at such an address returns data 0x00.
- R8: Each tx_req gives tx_valid with tx_byte in the next cycle. The first byte of a read frame (address byte bit 0 = 1) is the data at the read pointer. In protected mode the second byte is the CRC over the read address byte, the pointer and that data. Every later byte, and every byte after the data in plain mode, is 0xFF.
- R9: The register byte of any write frame loads the read pointer, even when the frame stops right after it.
- R10: crc_error stays set until err_clr is high. If a new error arrives in the same cycle as err_clr, the flag stays set.
- R11: Bytes after the CRC byte (protected mode) or after the data byte (plain mode) are ignored and cause no second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_en | input | 1 | Static mode select: 1 protected, 0 plain |
| rx_start | input | 1 | Frame start (or repeated start) pulse |
| rx_stop | input | 1 | Frame stop pulse |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to transmit |
| tx_valid | output | 1 | Transmit byte valid, one cycle after tx_req |
| tx_byte | output | 8 | Byte to transmit |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | 8 | Register write address |
| rf_wdata | output | 8 | Register write data |
| rf_raddr | output | 8 | Read pointer to the register file |
| rf_rdata | input | 8 | Register file read data at rf_raddr |
| err_clr | input | 1 | Clears the sticky CRC error flag |
| crc_error | output | 1 | Sticky CRC or truncation error flag |

## Verification
A corrupted CRC accumulator shows up at the write-strobe port as a good frame that is dropped, or a bad frame that is accepted, in the cycle after the CRC byte. A wrong frame-position state shows up as a write with the wrong address or data, or as a second strobe caused by trailing bytes. Both are caught within one cycle by the scoreboard, which pairs every strobe and every transmitted byte with an expected item. A stale read pointer or a bad read CRC shows up on tx_byte one cycle after the request.

// File: rtl/crcreg_pkg.sv
// Shared constants, types and the byte-wide CRC step for the register bridge.
// Assumes 8-bit bytes on the bus; the CRC is MSB-first with no output inversion.
package crcreg_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CRC_POLY = 8'h1D;
    localparam byte_t CRC_SEED = 8'hFF;

    // Frame position of the receive parser.
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ADDR,
        FS_REG,
        FS_DATA,
        FS_CHECK,
        FS_READ,
        FS_SKIP
    } frame_state_t;

    // Absorb one whole byte into the running CRC (unrolled over its bits).
    function automatic byte_t crc_step(input byte_t cur, input byte_t din);
        byte_t c;
        c = cur ^ din;
        for (int b = 0; b < BYTE_W; b++) begin
            c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/crc_accum.sv
// Running CRC over the leading bytes of a receive frame.
// Reseeded on init; absorbs one byte per absorb pulse until LEN bytes are in,
// then holds and raises crc_valid. Assumes init and absorb are not both high.
module crc_accum
    import crcreg_pkg::*;
#(
    parameter int LEN = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init,
    input  logic  absorb,
    input  byte_t din,
    output byte_t crc_q,
    output logic  crc_valid
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] count_q;

    assign crc_valid = (count_q == FULL);

    // Reseed, or fold in the next byte while fewer than LEN are absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q   <= CRC_SEED;
            count_q <= '0;
        end else if (init) begin
            crc_q   <= CRC_SEED;
            count_q <= '0;
        end else if (absorb && !crc_valid) begin
            crc_q   <= crc_step(crc_q, din);
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/frame_parser.sv
// Receive-side frame decoder: tracks byte position, loads the read pointer,
// gates register writes on CRC match and address range, and owns the sticky
// error flag. Assumes the front end never pulses start, stop and valid together.
module frame_parser
    import crcreg_pkg::*;
#(
    parameter byte_t REG_LIMIT = 8'h83
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  crc_en,
    input  logic  rx_start,
    input  logic  rx_stop,
    input  logic  rx_valid,
    input  byte_t rx_byte,
    input  logic  err_clr,
    input  byte_t crc_q,
    input  logic  crc_valid,
    output logic  acc_init,
    output logic  acc_absorb,
    output logic  rf_we,
    output byte_t rf_waddr,
    output byte_t rf_wdata,
    output byte_t ptr_q,
    output byte_t addr_q,
    output logic  rd_active,
    output logic  crc_error
);
    frame_state_t state_q;
    byte_t        data_q;
    logic         err_set;
    logic         in_range;

    assign acc_init   = rx_start;
    assign acc_absorb = rx_valid && !rx_start && !rx_stop &&
                        (state_q == FS_ADDR || state_q == FS_REG || state_q == FS_DATA);
    assign rd_active  = (state_q == FS_READ);
    assign in_range   = (ptr_q < REG_LIMIT);

    // Error when a CRC is due and the frame breaks off or the byte mismatches.
    always_comb begin
        err_set = 1'b0;
        if (state_q == FS_CHECK) begin
            if (rx_start || rx_stop) begin
                err_set = 1'b1;
            end else if (rx_valid && !(crc_valid && rx_byte == crc_q)) begin
                err_set = 1'b1;
            end
        end
    end

    // Sticky error flag; a new error wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_error <= 1'b0;
        end else begin
            crc_error <= (crc_error && !err_clr) || err_set;
        end
    end

    // Frame position, captured fields and the one-cycle write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            addr_q   <= '0;
            ptr_q    <= '0;
            data_q   <= '0;
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            if (rx_start) begin
                state_q <= FS_ADDR;
            end else if (rx_stop) begin
                state_q <= FS_IDLE;
            end else if (rx_valid) begin
                case (state_q)
                    FS_ADDR: begin
                        addr_q  <= rx_byte;
                        state_q <= rx_byte[0] ? FS_READ : FS_REG;
                    end
                    FS_REG: begin
                        ptr_q   <= rx_byte;
                        state_q <= FS_DATA;
                    end
                    FS_DATA: begin
                        data_q <= rx_byte;
                        if (crc_en) begin
                            state_q <= FS_CHECK;
                        end else begin
                            state_q  <= FS_SKIP;
                            rf_we    <= in_range;
                            rf_waddr <= ptr_q;
                            rf_wdata <= rx_byte;
                        end
                    end
                    FS_CHECK: begin
                        state_q <= FS_SKIP;
                        if (crc_valid && rx_byte == crc_q) begin
                            rf_we    <= in_range;
                            rf_waddr <= ptr_q;
                            rf_wdata <= data_q;
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/read_responder.sv
// Transmit side: answers each byte request of a read frame with the data at
// the read pointer, then its CRC in protected mode, then 0xFF filler.
// Assumes rf_rdata is valid combinationally for the presented pointer.
module read_responder
    import crcreg_pkg::*;
#(
    parameter byte_t REG_LIMIT = 8'h83
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  crc_en,
    input  logic  frame_start,
    input  logic  rd_active,
    input  logic  tx_req,
    input  byte_t addr_byte,
    input  byte_t ptr,
    input  byte_t rf_rdata,
    output logic  tx_valid,
    output byte_t tx_byte
);
    localparam byte_t FILL = 8'hFF;

    logic [1:0] idx_q;
    byte_t      held_q;
    byte_t      data_sel;
    byte_t      read_crc;

    assign data_sel = (ptr < REG_LIMIT) ? rf_rdata : '0;
    assign read_crc = crc_step(crc_step(crc_step(CRC_SEED, addr_byte), ptr), held_q);

    // Sequence the outgoing bytes of the current read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            held_q   <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= tx_req;
            if (frame_start) begin
                idx_q <= '0;
            end else if (tx_req) begin
                if (!rd_active) begin
                    tx_byte <= FILL;
                end else begin
                    if (idx_q != 2'd2) idx_q <= idx_q + 1'b1;
                    case (idx_q)
                        2'd0: begin
                            tx_byte <= data_sel;
                            held_q  <= data_sel;
                        end
                        2'd1:    tx_byte <= crc_en ? read_crc : FILL;
                        default: tx_byte <= FILL;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/crcreg_guard.sv
// Top of the CRC-checked register bridge: wires the receive parser, the CRC
// accumulator and the read responder. Assumes crc_en is static during frames.
module crcreg_guard
    import crcreg_pkg::*;
#(
    parameter byte_t REG_LIMIT  = 8'h83,
    parameter int    CRC_BYTES  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       crc_en,
    input  logic       rx_start,
    input  logic       rx_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       rf_we,
    output logic [7:0] rf_waddr,
    output logic [7:0] rf_wdata,
    output logic [7:0] rf_raddr,
    input  logic [7:0] rf_rdata,
    input  logic       err_clr,
    output logic       crc_error
);
    logic  acc_init;
    logic  acc_absorb;
    byte_t crc_q;
    logic  crc_valid;
    byte_t ptr_q;
    byte_t addr_q;
    logic  rd_active;

    assign rf_raddr = ptr_q;

    crc_accum #(.LEN(CRC_BYTES)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (acc_init),
        .absorb    (acc_absorb),
        .din       (rx_byte),
        .crc_q     (crc_q),
        .crc_valid (crc_valid)
    );

    frame_parser #(.REG_LIMIT(REG_LIMIT)) u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .crc_en     (crc_en),
        .rx_start   (rx_start),
        .rx_stop    (rx_stop),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .err_clr    (err_clr),
        .crc_q      (crc_q),
        .crc_valid  (crc_valid),
        .acc_init   (acc_init),
        .acc_absorb (acc_absorb),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .ptr_q      (ptr_q),
        .addr_q     (addr_q),
        .rd_active  (rd_active),
        .crc_error  (crc_error)
    );

    read_responder #(.REG_LIMIT(REG_LIMIT)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .crc_en      (crc_en),
        .frame_start (rx_start),
        .rd_active   (rd_active),
        .tx_req      (tx_req),
        .addr_byte   (addr_q),
        .ptr         (ptr_q),
        .rf_rdata    (rf_rdata),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte)
    );
endmodule

// File: rtl/crcreg_checker.sv
// Protocol properties of the register bridge, observed at its ports.
module crcreg_checker #(
    parameter logic [7:0] REG_LIMIT = 8'h83
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_req,
    input logic       tx_valid,
    input logic       rf_we,
    input logic [7:0] rf_waddr,
    input logic       err_clr,
    input logic       crc_error
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rf_we && !crc_error && !tx_valid));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    a_r4_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !$rose(crc_error));

    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr < REG_LIMIT));

    a_r8_tx_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_error && !err_clr) |=> crc_error);

    a_r10_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_error) |-> $past(err_clr));
endmodule

bind crcreg_guard crcreg_checker #(.REG_LIMIT(REG_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .tx_valid  (tx_valid),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .err_clr   (err_clr),
    .crc_error (crc_error)
);

// File: tb/sim_crcreg_guard.sv
module sim_crcreg_guard;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] TGT = 7'h08;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_en = 1'b1;
    logic       rx_start = 1'b0, rx_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       rf_we;
    logic [7:0] rf_waddr, rf_wdata, rf_raddr, rf_rdata;
    logic       err_clr = 1'b0;
    logic       crc_error;

    typedef struct { logic [7:0] a; logic [7:0] d; string tag; } wr_item_t;
    typedef struct { logic [7:0] b; string tag; } tx_item_t;
    wr_item_t wq[$];
    tx_item_t tq[$];

    logic [7:0] bmem [0:255];
    logic [7:0] model [0:255];
    logic [7:0] bptr = 8'h00;
    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crcreg_guard u0 (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en),
        .rx_start(rx_start), .rx_stop(rx_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .err_clr(err_clr), .crc_error(crc_error)
    );

    // Register file stand-in.
    assign rf_rdata = bmem[rf_raddr];
    always @(posedge clk) if (rf_we) bmem[rf_waddr] <= rf_wdata;

    // Reference CRC fed one bit at a time (R2).
    function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d);
        logic [23:0] s;
        logic [7:0]  c;
        logic        fb;
        s = {a, r, d};
        c = 8'hFF;
        for (int i = 23; i >= 0; i--) begin
            fb = c[7] ^ s[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pairs every strobe and every transmitted byte with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rf_we) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R7/R11 unexpected write", {rf_waddr, rf_wdata}, 0);
                end else begin
                    wr_item_t w;
                    w = wq.pop_front();
                    check(rf_waddr == w.a && rf_wdata == w.d, w.tag, {rf_waddr, rf_wdata}, {w.a, w.d});
                end
            end
            if (tx_valid) begin
                if (tq.size() == 0) begin
                    check(1'b0, "R8 unexpected tx", tx_byte, 0);
                end else begin
                    tx_item_t t;
                    t = tq.pop_front();
                    check(tx_byte == t.b, t.tag, tx_byte, t.b);
                end
            end
        end
    end

    task automatic ev_start();
        @(negedge clk) rx_start = 1'b1;
        @(negedge clk) rx_start = 1'b0;
    endtask
    task automatic ev_stop();
        @(negedge clk) rx_stop = 1'b1;
        @(negedge clk) rx_stop = 1'b0;
    endtask
    task automatic ev_byte(input logic [7:0] b, input bit clr);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; err_clr = clr; end
        @(negedge clk) begin rx_valid = 1'b0; err_clr = 1'b0; end
    endtask

    // mode: 1 good CRC, 2 bad CRC, 3 truncated before CRC (ignored in plain mode).
    task automatic wr_frame(input logic [7:0] ra, input logic [7:0] d, input int mode,
                            input bit extra, input bit clr_last, input string tag);
        logic [7:0] c;
        bit ok;
        c  = ref_crc({TGT, 1'b0}, ra, d);
        ok = (ra < 8'h83) && (!crc_en || mode == 1);
        bptr = ra;
        ev_start();
        ev_byte({TGT, 1'b0}, 1'b0);
        ev_byte(ra, 1'b0);
        if (ok) begin
            wq.push_back('{ra, d, tag});
            model[ra] = d;
        end
        ev_byte(d, 1'b0);
        if (crc_en && mode == 1) ev_byte(c, clr_last);
        if (crc_en && mode == 2) ev_byte(c ^ 8'h01, clr_last);
        if (extra) ev_byte(8'h5A, 1'b0);
        ev_stop();
    endtask

    task automatic set_ptr(input logic [7:0] ra);
        bptr = ra;
        ev_start();
        ev_byte({TGT, 1'b0}, 1'b0);
        ev_byte(ra, 1'b0);
        ev_stop();
    endtask

    task automatic rd_frame(input int n, input string tag);
        logic [7:0] d;
        logic [7:0] e;
        d = (bptr < 8'h83) ? model[bptr] : 8'h00;
        ev_start();
        ev_byte({TGT, 1'b1}, 1'b0);
        for (int i = 0; i < n; i++) begin
            if (i == 0) e = d;
            else if (i == 1 && crc_en) e = ref_crc({TGT, 1'b1}, bptr, d);
            else e = 8'hFF;
            tq.push_back('{e, tag});
            @(negedge clk) tx_req = 1'b1;
            @(negedge clk) tx_req = 1'b0;
        end
        ev_stop();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin bmem[i] = 8'h00; model[i] = 8'h00; end
        repeat (3) @(negedge clk);
        check(!rf_we && !crc_error && !tx_valid, "R1 reset outputs", {rf_we, crc_error, tx_valid}, 0);
        check(rf_raddr == 8'h00, "R1 reset pointer", rf_raddr, 0);
        @(negedge clk) rst_n = 1'b1;

        // Protected writes, several addresses and data patterns (R2, R3).
        wr_frame(8'h10, 8'hA5, 1, 0, 0, "R3 write 10");
        wr_frame(8'h00, 8'h00, 1, 0, 0, "R3 write 00");
        wr_frame(8'h82, 8'hFF, 1, 0, 0, "R2 write top");
        wr_frame(8'h5E, 8'h3C, 1, 1, 0, "R11 write then trailing byte");
        check(!crc_error, "R3 no error on good frames", crc_error, 0);

        // Mismatched CRC (R4), then clear (R10).
        wr_frame(8'h11, 8'h22, 2, 0, 0, "R4 bad crc");
        check(crc_error, "R4 error set", crc_error, 1);
        repeat (3) @(negedge clk);
        check(crc_error, "R10 error stays", crc_error, 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        check(!crc_error, "R10 error cleared", crc_error, 0);

        // Truncated frame (R5).
        ev_start(); ev_byte({TGT, 1'b0}, 0); ev_byte(8'h12, 0); ev_byte(8'h44, 0); ev_stop();
        bptr = 8'h12;
        check(crc_error, "R5 truncated sets error", crc_error, 1);
        // New error with clear in the same cycle keeps the flag (R10).
        wr_frame(8'h13, 8'h55, 2, 0, 1, "R10 set beats clear");
        check(crc_error, "R10 set beats clear", crc_error, 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;

        // Out-of-range write with a good CRC (R7).
        wr_frame(8'h83, 8'h66, 1, 0, 0, "R7 range");
        check(!crc_error, "R7 no error on range reject", crc_error, 0);

        // Reads: pointer loaded by a register-only frame (R9), data, CRC, filler (R8).
        set_ptr(8'h10);
        check(rf_raddr == 8'h10, "R9 pointer loaded", rf_raddr, 8'h10);
        rd_frame(3, "R8 read 10");
        set_ptr(8'h82);
        rd_frame(2, "R8 read top");
        set_ptr(8'h83);
        rd_frame(2, "R7 read out of range");
        wr_frame(8'h00, 8'hC3, 1, 0, 0, "R3 write 00 again");
        rd_frame(2, "R9 pointer from write");

        // Plain mode (R6, R11).
        @(negedge clk) crc_en = 1'b0;
        wr_frame(8'h20, 8'h77, 1, 1, 0, "R6 plain write");
        wr_frame(8'h90, 8'h01, 1, 0, 0, "R7 plain range");
        check(!crc_error, "R6 no error in plain mode", crc_error, 0);
        set_ptr(8'h20);
        rd_frame(2, "R6 plain read");

        repeat (5) @(negedge clk);
        check(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
        check(tq.size() == 0, "R8 all tx bytes seen", tq.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule